// File: doc/BRIEF.md
# Overlay Pixel Format Decoder

The decoder takes packed overlay source words, one group of up to eight bytes per transfer, and turns each group into two or four pixels of 8-bit red, green and blue. A 3-bit mode code sent with each group picks the source format. The formats are two luma/chroma 4:2:2 layouts with different conversion matrices, a 2:1:1 luma/chroma layout, 15-bit and 16-bit packed RGB, and 8-bit palette indices. Luma/chroma conversion is done in 8-bit fixed point with signed intermediates. Every converted channel is then clipped to the range 0..255.

Decoded pixels are written into an eight-entry ring and leave it one per cycle on a valid/ready output stream. A palette pixel is not resolved inside the block. While a palette entry is at the head of the ring, its index is driven on `lut_index`, and the colour returned on `lut_rgb` is passed straight to `out_rgb`.

Back-pressure rules:
- An input group is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high only when the ring has at least as many free entries as the pixel count of the current `in_mode`.
- An output pixel leaves on a clock edge where `out_valid` and `out_ready` are both high.
- While `out_valid` is high and `out_ready` is low, the head pixel is held.

Top module: `ovd_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 for every mode.
- R2: Mode 0 reads bytes in the order U, Y0, V, Y1. Byte k is `in_bytes[8k+7:8k]`. The mode yields 2 pixels. Each luma is expanded as (298·(Y−16))>>>8, and U and V are offset by −128. The chroma terms are dR=(309·V)>>>8, dG=(100·U+208·V)>>>8 and dB=(516·U)>>>8. Each pixel is R=Y'+dR, G=Y'−dG, B=Y'+dB, packed as `out_rgb` = {R[23:16], G[15:8], B[7:0]}.
- R3: Mode 1 reads bytes in the order Y0, Cr, Y1, Cb, with no luma expansion. It yields 2 pixels with dR=(359·Cr)>>>8, dG=(88·Cb+183·Cr)>>>8 and dB=(453·Cb)>>>8, where Cb and Cr are offset by −128.
- R4: Mode 3 reads bytes in the order U, Y0, Y1, V, Y2, Y3. It yields 4 pixels that share one chroma pair and use the arithmetic of R2.
- R5: Any channel result below 0 becomes 0, and any result above 255 becomes 255.
- R6: Mode 4 reads four little-endian 16-bit words (word i = {byte 2i+1, byte 2i}) and yields 4 pixels. R = bits 4:0, G = bits 9:5 and B = bits 14:10, each widened as {c, c[4:2]}. Bit 15 is ignored.
- R7: Mode 5 uses the same words as R6. R = bits 4:0 and B = bits 15:11, each widened as {c, c[4:2]}. G = bits 10:5, widened as {c, c[5:4]}.
- R8: Mode 2 yields 4 pixels from bytes 0..3 as palette indices. While such a pixel is at the head, `lut_index` carries its index and `out_rgb` equals `lut_rgb`.
- R9: Groups with modes 6 and 7 are accepted and produce no pixels.
- R10: Pixels leave in group order, and within a group in ascending pixel number.
- R11: `in_ready` is low exactly when the free entries are fewer than the current mode's pixel count. While `out_valid` is high and `out_ready` is low, the head pixel stays unchanged.
- R12: The ring holds up to 8 pixels and wraps around without loss over many groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Ring can take a group of the current mode |
| in_mode | input | 3 | Source format code |
| in_bytes | input | 64 | Source group, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Head pixel available |
| out_ready | input | 1 | Consumer takes the head pixel |
| out_rgb | output | 24 | Pixel {R, G, B} |
| lut_index | output | 8 | Palette index of the head pixel |
| lut_rgb | input | 24 | Colour returned by the external palette |

## Verification
Mid-range luma/chroma samples give neither-end results and show that the byte order and matrix choice are right; the two 4:2:2 modes are fed the same bytes in different roles. Samples near the luma and chroma extremes push the results past both ends, which exposes any missing clipping or a wrong shift sign. Packed RGB words with one field all ones separate the three channel positions and the two widening rules, and a set bit 15 in 15-bit mode shows that the bit is ignored. A stalled consumer with mixed two- and four-pixel groups probes the free-space rule, the holding of the head pixel and the wrap-around order.

// File: rtl/ovd_pkg.sv
package ovd_pkg;

  localparam logic [2:0] MD_YUV422 = 3'd0;
  localparam logic [2:0] MD_YCC    = 3'd1;
  localparam logic [2:0] MD_PAL    = 3'd2;
  localparam logic [2:0] MD_YUV211 = 3'd3;
  localparam logic [2:0] MD_RGB15  = 3'd4;
  localparam logic [2:0] MD_RGB16  = 3'd5;

  typedef struct packed {
    logic        is_idx;
    logic [23:0] rgb;
  } pix_t;

  // number of pixels one group of the given mode produces
  function automatic logic [2:0] pix_need(input logic [2:0] m);
    case (m)
      MD_YUV422, MD_YCC: return 3'd2;
      MD_PAL, MD_YUV211, MD_RGB15, MD_RGB16: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] sat8(input logic signed [11:0] x);
    if (x < 0) return 8'h00;
    else if (x > 12'sd255) return 8'hFF;
    else return x[7:0];
  endfunction

  function automatic logic [7:0] wid5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] wid6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

endpackage

// File: rtl/ovd_chroma.sv
// Chroma difference terms for one matrix variant.
module ovd_chroma #(
  parameter bit YCC = 1'b0
) (
  input  logic [7:0]         c_b,
  input  logic [7:0]         c_r,
  output logic signed [11:0] d_r,
  output logic signed [11:0] d_g,
  output logic signed [11:0] d_b
);
  localparam logic signed [19:0] KR  = YCC ? 20'sd359 : 20'sd309;
  localparam logic signed [19:0] KGB = YCC ? 20'sd88  : 20'sd100;
  localparam logic signed [19:0] KGR = YCC ? 20'sd183 : 20'sd208;
  localparam logic signed [19:0] KB  = YCC ? 20'sd453 : 20'sd516;

  logic signed [8:0]  sb, sr;
  logic signed [19:0] sb20, sr20, pr, pg, pb;

  always_comb begin
    sb   = $signed({1'b0, c_b}) - 9'sd128;
    sr   = $signed({1'b0, c_r}) - 9'sd128;
    sb20 = {{11{sb[8]}}, sb};
    sr20 = {{11{sr[8]}}, sr};
    pr   = sr20 * KR;
    pg   = sb20 * KGB + sr20 * KGR;
    pb   = sb20 * KB;
    d_r  = 12'(pr >>> 8);
    d_g  = 12'(pg >>> 8);
    d_b  = 12'(pb >>> 8);
  end
endmodule

// File: rtl/ovd_pixel.sv
// Luma handling plus clipped channel sums for one pixel.
module ovd_pixel (
  input  logic [7:0]         y,
  input  logic               expand,
  input  logic signed [11:0] d_r,
  input  logic signed [11:0] d_g,
  input  logic signed [11:0] d_b,
  output logic [23:0]        rgb
);
  import ovd_pkg::*;

  logic signed [19:0] yoff, yprod;
  logic signed [11:0] lum, sr, sg, sb;

  always_comb begin
    yoff  = {12'b0, y} - 20'sd16;
    yprod = yoff * 20'sd298;
    lum   = expand ? 12'(yprod >>> 8) : {4'b0, y};
    sr    = lum + d_r;
    sg    = lum - d_g;
    sb    = lum + d_b;
    rgb   = {sat8(sr), sat8(sg), sat8(sb)};
  end
endmodule

// File: rtl/ovd_ring.sv
// Multi-write, single-read pixel ring.
module ovd_ring #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 25,
  parameter int MAXW  = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = AW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNTW-1:0]        wr_num,
  input  logic [MAXW*WIDTH-1:0]  wr_data,
  input  logic                   rd_en,
  output logic [CNTW-1:0]        free_cnt,
  output logic                   empty,
  output logic [WIDTH-1:0]       rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNTW-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      for (int i = 0; i < MAXW; i++)
        if (CNTW'(i) < wr_num)
          mem[wr_ptr + AW'(i)] <= wr_data[i*WIDTH +: WIDTH];
      wr_ptr <= wr_ptr + wr_num[AW-1:0];
      rd_ptr <= rd_ptr + AW'(rd_en);
      cnt    <= cnt + wr_num - CNTW'(rd_en);
    end
  end

  assign free_cnt = CNTW'(DEPTH) - cnt;
  assign empty    = (cnt == '0);
  assign rd_data  = mem[rd_ptr];
endmodule

// File: rtl/ovd_decoder.sv
module ovd_decoder #(
  parameter int RING_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_mode,
  input  logic [63:0] in_bytes,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_rgb,
  output logic [7:0]  lut_index,
  input  logic [23:0] lut_rgb
);
  import ovd_pkg::*;

  localparam int GRP_BYTES = 8;
  localparam int MAX_PIX   = 4;
  localparam int PW        = $bits(pix_t);
  localparam int CNTW      = $clog2(RING_DEPTH) + 1;

  logic [7:0] bt [GRP_BYTES];
  for (genvar k = 0; k < GRP_BYTES; k++) begin : g_bytes
    assign bt[k] = in_bytes[8*k +: 8];
  end

  // chroma terms: one instance per matrix
  logic signed [11:0] dr [2], dg [2], db [2];
  logic [7:0] cb_sel [2], cr_sel [2];
  assign cb_sel[0] = bt[0];
  assign cr_sel[0] = (in_mode == MD_YUV211) ? bt[3] : bt[2];
  assign cb_sel[1] = bt[3];
  assign cr_sel[1] = bt[1];

  for (genvar m = 0; m < 2; m++) begin : g_chroma
    ovd_chroma #(.YCC(m == 1)) u_chroma (
      .c_b(cb_sel[m]), .c_r(cr_sel[m]),
      .d_r(dr[m]), .d_g(dg[m]), .d_b(db[m])
    );
  end

  // luma byte selection per pixel slot
  logic [7:0] yraw [MAX_PIX];
  always_comb begin
    for (int i = 0; i < MAX_PIX; i++) yraw[i] = 8'h00;
    case (in_mode)
      MD_YUV422: begin yraw[0] = bt[1]; yraw[1] = bt[3]; end
      MD_YCC:    begin yraw[0] = bt[0]; yraw[1] = bt[2]; end
      MD_YUV211: begin
        yraw[0] = bt[1]; yraw[1] = bt[2];
        yraw[2] = bt[4]; yraw[3] = bt[5];
      end
      default: ;
    endcase
  end

  logic        use_ycc;
  logic [23:0] conv [MAX_PIX];
  assign use_ycc = (in_mode == MD_YCC);

  for (genvar p = 0; p < MAX_PIX; p++) begin : g_pix
    ovd_pixel u_pix (
      .y(yraw[p]), .expand(!use_ycc),
      .d_r(use_ycc ? dr[1] : dr[0]),
      .d_g(use_ycc ? dg[1] : dg[0]),
      .d_b(use_ycc ? db[1] : db[0]),
      .rgb(conv[p])
    );
  end

  // group assembly
  pix_t                pix [MAX_PIX];
  logic [MAX_PIX*PW-1:0] wr_flat;
  always_comb begin
    for (int i = 0; i < MAX_PIX; i++) begin
      logic [15:0] w;
      w = {bt[2*i+1], bt[2*i]};
      pix[i] = '0;
      case (in_mode)
        MD_YUV422, MD_YCC, MD_YUV211: pix[i].rgb = conv[i];
        MD_PAL: begin
          pix[i].is_idx = 1'b1;
          pix[i].rgb    = {16'h0000, bt[i]};
        end
        MD_RGB15: pix[i].rgb = {wid5(w[4:0]), wid5(w[9:5]), wid5(w[14:10])};
        MD_RGB16: pix[i].rgb = {wid5(w[4:0]), wid6(w[10:5]), wid5(w[15:11])};
        default: ;
      endcase
      wr_flat[i*PW +: PW] = pix[i];
    end
  end

  // ring control
  logic [CNTW-1:0] need, free_cnt, wr_num;
  logic            empty, in_fire;
  pix_t            head;

  assign need     = CNTW'(pix_need(in_mode));
  assign in_ready = (free_cnt >= need);
  assign in_fire  = in_valid && in_ready;
  assign wr_num   = in_fire ? need : '0;

  ovd_ring #(.DEPTH(RING_DEPTH), .WIDTH(PW), .MAXW(MAX_PIX)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_num(wr_num), .wr_data(wr_flat),
    .rd_en(out_valid && out_ready),
    .free_cnt(free_cnt), .empty(empty), .rd_data(head)
  );

  assign out_valid = !empty;
  assign lut_index = head.rgb[7:0];
  assign out_rgb   = head.is_idx ? lut_rgb : head.rgb;
endmodule

// File: rtl/ovd_decoder_chk.sv
module ovd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_mode,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] lut_index
);
  // an empty ring always has room for any group
  p_empty_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // a refused group implies pixels are waiting
  p_blocked_has_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> out_valid);

  // stalled head stays put
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(lut_index)));

  // an accepted decodable group makes pixels available next cycle
  p_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode <= 3'd5) |=> out_valid);

  // undefined modes write nothing
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode >= 3'd6 && !out_valid) |=> !out_valid);
endmodule

bind ovd_decoder ovd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .out_valid(out_valid), .out_ready(out_ready),
  .lut_index(lut_index)
);

// File: tb/ovd_decoder_test.sv
`timescale 1ns/1ps
module ovd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_mode = 3'd0;
  logic [63:0] in_bytes = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_rgb;
  logic [7:0]  lut_index;
  logic [23:0] lut_rgb;
  logic        toggle_en = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [23:0] rx_q [$];
  logic [23:0] exp_q [$];

  always #2.5 clk = ~clk;

  ovd_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_bytes(in_bytes), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb), .lut_index(lut_index),
    .lut_rgb(lut_rgb)
  );

  function automatic logic [23:0] lutf(input logic [7:0] idx);
    return {idx ^ 8'hA5, ~idx, idx};
  endfunction
  assign lut_rgb = lutf(lut_index);

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) rx_q.push_back(out_rgb);

  always @(posedge clk) begin
    #1;
    if (toggle_en) out_ready = ~out_ready;
  end

  // ---------- reference model ----------
  function automatic int sat(input int x);
    return (x < 0) ? 0 : ((x > 255) ? 255 : x);
  endfunction

  function automatic logic [23:0] pack(input int r, input int g, input int b);
    return {8'(sat(r)), 8'(sat(g)), 8'(sat(b))};
  endfunction

  function automatic logic [23:0] ref_yuv(input int y, input int u, input int v);
    int yl, uu, vv;
    yl = (298 * (y - 16)) >>> 8;
    uu = u - 128; vv = v - 128;
    return pack(yl + ((309 * vv) >>> 8), yl - ((100 * uu + 208 * vv) >>> 8),
                yl + ((516 * uu) >>> 8));
  endfunction

  function automatic logic [23:0] ref_ycc(input int y, input int cb, input int cr);
    int b, r;
    b = cb - 128; r = cr - 128;
    return pack(y + ((359 * r) >>> 8), y - ((88 * b + 183 * r) >>> 8),
                y + ((453 * b) >>> 8));
  endfunction

  function automatic logic [23:0] ref_555(input logic [15:0] w);
    return {w[4:0], w[4:2], w[9:5], w[9:7], w[14:10], w[14:12]};
  endfunction

  function automatic logic [23:0] ref_565(input logic [15:0] w);
    return {w[4:0], w[4:2], w[10:5], w[10:9], w[15:11], w[15:13]};
  endfunction

  // ---------- helpers ----------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] m, input logic [63:0] d);
    @(posedge clk); #1;
    in_mode = m; in_bytes = d; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int c = 0; c < 300 && rx_q.size() < exp_q.size(); c++) @(posedge clk);
    repeat (4) @(posedge clk);
    check(req, rx_q.size(), exp_q.size());
    while (exp_q.size() > 0 && rx_q.size() > 0)
      check(req, rx_q.pop_front(), exp_q.pop_front());
    rx_q.delete(); exp_q.delete();
  endtask

  task automatic send422(input int u, input int y0, input int v, input int y1);
    exp_q.push_back(ref_yuv(y0, u, v));
    exp_q.push_back(ref_yuv(y1, u, v));
    send(3'd0, {32'h0, 8'(y1), 8'(v), 8'(y0), 8'(u)});
  endtask

  // ---------- scenarios ----------
  task automatic t_reset_r1();
    in_mode = 3'd4;
    @(negedge clk);
    check("R1", out_valid, 0);
    check("R1", in_ready, 1);
  endtask

  task automatic t_yuv422_r2();
    send422(128, 16, 128, 235);
    send422(90, 100, 200, 150);
    send422(200, 81, 60, 40);
    drain("R2");
  endtask

  task automatic t_ycc_r3();
    exp_q.push_back(ref_ycc(100, 128, 128)); exp_q.push_back(ref_ycc(200, 128, 128));
    send(3'd1, {32'h0, 8'd128, 8'd200, 8'd128, 8'd100});
    exp_q.push_back(ref_ycc(50, 30, 200)); exp_q.push_back(ref_ycc(180, 30, 200));
    send(3'd1, {32'h0, 8'd30, 8'd180, 8'd200, 8'd50});
    drain("R3");
  endtask

  task automatic t_yuv211_r4();
    exp_q.push_back(ref_yuv(30, 100, 180));  exp_q.push_back(ref_yuv(60, 100, 180));
    exp_q.push_back(ref_yuv(120, 100, 180)); exp_q.push_back(ref_yuv(220, 100, 180));
    send(3'd3, {16'h0, 8'd220, 8'd120, 8'd180, 8'd60, 8'd30, 8'd100});
    drain("R4");
  endtask

  task automatic t_sat_r5();
    // hand-computed: Y'=254, dR=153, dG=53, dB=-258
    exp_q.push_back(24'hFFC900); exp_q.push_back(24'hFFC900);
    send(3'd0, {32'h0, 8'd235, 8'd255, 8'd235, 8'd0});
    exp_q.push_back(ref_yuv(0, 255, 0)); exp_q.push_back(ref_yuv(255, 255, 0));
    send(3'd0, {32'h0, 8'd255, 8'd0, 8'd0, 8'd255});
    drain("R5");
  endtask

  task automatic t_rgb15_r6();
    logic [15:0] w [4] = '{16'h8000, 16'h7FFF, 16'h001F, 16'h4321};
    for (int i = 0; i < 4; i++) exp_q.push_back(ref_555(w[i]));
    send(3'd4, {w[3], w[2], w[1], w[0]});
    drain("R6");
  endtask

  task automatic t_rgb16_r7();
    logic [15:0] w [4] = '{16'hFFFF, 16'h07E0, 16'hF800, 16'h1234};
    for (int i = 0; i < 4; i++) exp_q.push_back(ref_565(w[i]));
    send(3'd5, {w[3], w[2], w[1], w[0]});
    drain("R7");
  endtask

  task automatic t_palette_r8();
    out_ready = 1'b0;
    send(3'd2, {32'h0, 8'hFF, 8'h80, 8'h7F, 8'h00});
    @(negedge clk);
    check("R8", lut_index, 8'h00);
    check("R8", out_rgb, lutf(8'h00));
    exp_q.push_back(lutf(8'h00)); exp_q.push_back(lutf(8'h7F));
    exp_q.push_back(lutf(8'h80)); exp_q.push_back(lutf(8'hFF));
    @(posedge clk); #1; out_ready = 1'b1;
    drain("R8");
  endtask

  task automatic t_undef_r9();
    out_ready = 1'b0;
    send(3'd6, 64'h0123_4567_89AB_CDEF);
    send(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", out_valid, 0);
    exp_q.push_back(ref_555(16'h1111)); exp_q.push_back(ref_555(16'h2222));
    exp_q.push_back(ref_555(16'h3333)); exp_q.push_back(ref_555(16'h4444));
    send(3'd4, 64'h4444_3333_2222_1111);
    @(posedge clk); #1; out_ready = 1'b1;
    drain("R9");
  endtask

  task automatic t_backpressure_r11();
    logic [23:0] held;
    out_ready = 1'b0;
    send422(10, 20, 30, 40);
    send422(50, 60, 70, 80);
    send422(90, 100, 110, 120);
    @(posedge clk); #1; in_mode = 3'd4;
    @(negedge clk); check("R11", in_ready, 0);
    @(posedge clk); #1; in_mode = 3'd0;
    @(negedge clk); check("R11", in_ready, 1);
    send422(130, 140, 150, 160);
    @(negedge clk);
    check("R11", in_ready, 0);
    check("R11", out_valid, 1);
    held = out_rgb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", out_rgb, held);
    @(posedge clk); #1; out_ready = 1'b1;
    drain("R10");
  endtask

  task automatic t_wrap_r12();
    toggle_en = 1'b1;
    for (int g = 0; g < 10; g++) begin
      logic [15:0] w [4];
      for (int i = 0; i < 4; i++) begin
        w[i] = 16'(g * 16'h1357 + i * 16'h0F0F + 16'h00A1);
        exp_q.push_back(ref_565(w[i]));
      end
      send(3'd5, {w[3], w[2], w[1], w[0]});
    end
    for (int c = 0; c < 200 && rx_q.size() < exp_q.size(); c++) @(posedge clk);
    toggle_en = 1'b0;
    @(posedge clk); #1; out_ready = 1'b1;
    drain("R12");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_r1();
    t_yuv422_r2();
    t_ycc_r3();
    t_yuv211_r4();
    t_sat_r5();
    t_rgb15_r6();
    t_rgb16_r7();
    t_palette_r8();
    t_undef_r9();
    t_backpressure_r11();
    t_wrap_r12();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule